// File: doc/BRIEF.md
# Branch Resolution and Next-Fetch Address Unit

This unit resolves control flow for one branch or jump per cycle in a pipelined core whose architecture has a single delay slot. Each cycle that `in_valid` is high it accepts the instruction's address, a 4-bit control-flow class, a likely flag, the 16-bit branch displacement, the 26-bit jump index, two 64-bit operand values and the destination register index. One clock later it presents the address to fetch after the delay slot, a taken flag, an annul flag that squashes the delay-slot instruction, and a link write request (register index and return address) for the register file.

Conditional branches compare two full 64-bit operands for equality or test one operand's sign and zero-ness. The likely flag makes a not-taken conditional branch squash its delay slot. The link-and-branch forms always write the return address, whatever the outcome. Direct jumps build their target from the upper bits of the delay-slot address. Register jumps take the low address bits of the first operand. The register-linking jump writes only to a nonzero destination, and its target is always the operand value that came with the instruction.

Top module: `bnpc_unit`

## Requirements
- R1: After reset, and one cycle after any cycle with `in_valid` low, `out_valid`, `out_taken`, `out_annul` and `out_link_we` are 0 and `out_link_idx`/`out_link_addr` are 0. An idle cycle leaves `out_next_pc` unchanged. Results of an accepted instruction appear on the outputs exactly one clock after the edge that samples it.
- R2: Class 1 (equal) is taken when all 64 bits of `in_opa` and `in_opb` match. Class 2 (not equal) is taken when any bit differs.
- R3: Class 3 (>=0), 4 (>0), 5 (<=0) and 6 (<0) test `in_opa` as a signed 64-bit value. Classes 7 (>=0 with link) and 8 (<0 with link) test the same as 3 and 6.
- R4: A taken conditional branch sets `out_taken`, leaves `out_annul` low and gives `out_next_pc` = `in_pc`+4 + (sign-extended `in_off` × 4).
- R5: A not-taken conditional branch with `in_likely` low gives `out_taken`=0, `out_annul`=0 and `out_next_pc` = `in_pc`+8.
- R6: A not-taken conditional branch with `in_likely` high gives `out_annul`=1, `out_taken`=0 and `out_next_pc` = `in_pc`+8. A taken one does not annul.
- R7: Classes 7 and 8 raise `out_link_we` with `out_link_idx`=31 and `out_link_addr`=`in_pc`+8 whether or not the branch is taken.
- R8: Class 9 (jump) and class 10 (jump with link) are always taken, with target {(`in_pc`+4)[31:28], `in_jidx`, 2'b00}. Class 10 writes index 31 with `in_pc`+8.
- R9: Class 11 (register jump) and class 12 (register jump with link) are always taken, with target `in_opa`[31:0]. Class 12 raises `out_link_we` with index `in_rd` and address `in_pc`+8 only when `in_rd` is nonzero, and the target stays `in_opa` even when the link goes to the register that supplied it.
- R10: `in_likely` has no effect on classes 0 and 9 to 15: `out_annul` stays 0 for them.
- R11: Class 0 and the unused classes 13 to 15 are sequential: `out_taken`=0, no link, `out_next_pc`=`in_pc`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_pc | input | 32 | Address of the branch or jump |
| in_op | input | 4 | Control-flow class (0 to 12, see R2 to R11) |
| in_likely | input | 1 | Squash the delay slot when not taken |
| in_off | input | 16 | Branch displacement in words |
| in_jidx | input | 26 | Direct jump word index |
| in_opa | input | 64 | First operand (compare value or register target) |
| in_opb | input | 64 | Second operand for equal/not-equal |
| in_rd | input | 5 | Destination index for the register-linking jump |
| out_valid | output | 1 | Result present |
| out_next_pc | output | 32 | Address to fetch after the delay slot |
| out_taken | output | 1 | Control moves to a target |
| out_annul | output | 1 | Squash the delay-slot instruction |
| out_link_we | output | 1 | Link write request |
| out_link_idx | output | 5 | Link register index |
| out_link_addr | output | 32 | Return address to write |

## Verification
The only state is the output register bank plus the held fetch address, so any fault in decision or target logic shows up on the ports in the very next cycle after the instruction is sampled. A wrong hold of `out_next_pc` across idle cycles is visible on the first idle cycle. A comparison that ignores high operand bits shows as a wrong `out_taken` and a wrong address only when the operands differ solely in those bits, so such pairs and sign-boundary values are applied on purpose. Every output is compared against a behavioural model on every cycle.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;
  typedef enum logic [3:0] {
    CF_SEQ      = 4'd0,
    CF_EQ       = 4'd1,
    CF_NE       = 4'd2,
    CF_GEZ      = 4'd3,
    CF_GTZ      = 4'd4,
    CF_LEZ      = 4'd5,
    CF_LTZ      = 4'd6,
    CF_GEZ_LNK  = 4'd7,
    CF_LTZ_LNK  = 4'd8,
    CF_JIMM     = 4'd9,
    CF_JIMM_LNK = 4'd10,
    CF_JREG     = 4'd11,
    CF_JREG_LNK = 4'd12
  } cf_op_e;

  localparam int unsigned CF_OP_W = 4;
endpackage

// File: rtl/bnpc_cond.sv
module bnpc_cond
  import bnpc_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  cf_op_e            op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              is_cond,
  output logic              hit
);
  logic same, sgn, zro;

  assign same = (opa == opb);
  assign sgn  = opa[DATA_W-1];
  assign zro  = (opa == '0);

  always_comb begin
    is_cond = 1'b1;
    hit     = 1'b0;
    unique case (op)
      CF_EQ:                  hit = same;
      CF_NE:                  hit = !same;
      CF_GEZ, CF_GEZ_LNK:     hit = !sgn;
      CF_GTZ:                 hit = !sgn && !zro;
      CF_LEZ:                 hit = sgn || zro;
      CF_LTZ, CF_LTZ_LNK:     hit = sgn;
      default:                is_cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/bnpc_target.sv
module bnpc_target #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [OFF_W-1:0]  off,
  input  logic [JIDX_W-1:0] jidx,
  output logic [PC_W-1:0]   seq4,
  output logic [PC_W-1:0]   seq8,
  output logic [PC_W-1:0]   br_tgt,
  output logic [PC_W-1:0]   jmp_tgt
);
  localparam int unsigned EXT_W  = PC_W - OFF_W - 2;
  localparam int unsigned HIGH_W = PC_W - JIDX_W - 2;

  logic [PC_W-1:0] disp;

  assign seq4 = pc + PC_W'(4);
  assign seq8 = pc + PC_W'(8);

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
    end else begin : g_trunc
      assign disp = PC_W'({off, 2'b00});
    end
  endgenerate

  assign br_tgt  = seq4 + disp;
  assign jmp_tgt = {seq4[PC_W-1 -: HIGH_W], jidx, 2'b00};
endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned OFF_W    = 16,
  parameter int unsigned JIDX_W   = 26,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [3:0]        in_op,
  input  logic              in_likely,
  input  logic [OFF_W-1:0]  in_off,
  input  logic [JIDX_W-1:0] in_jidx,
  input  logic [DATA_W-1:0] in_opa,
  input  logic [DATA_W-1:0] in_opb,
  input  logic [REG_W-1:0]  in_rd,
  output logic              out_valid,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_taken,
  output logic              out_annul,
  output logic              out_link_we,
  output logic [REG_W-1:0]  out_link_idx,
  output logic [PC_W-1:0]   out_link_addr
);
  localparam logic [REG_W-1:0] LNK_IDX = REG_W'(LINK_REG);

  cf_op_e          op;
  logic            is_cond, hit;
  logic [PC_W-1:0] seq4, seq8, br_tgt, jmp_tgt;

  logic            nx_taken, nx_annul, nx_lwe;
  logic [REG_W-1:0] nx_lidx;
  logic [PC_W-1:0] nx_pc;

  assign op = cf_op_e'(in_op);

  bnpc_cond #(.DATA_W(DATA_W)) u_cond (
    .op      (op),
    .opa     (in_opa),
    .opb     (in_opb),
    .is_cond (is_cond),
    .hit     (hit)
  );

  bnpc_target #(.PC_W(PC_W), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) u_tgt (
    .pc      (in_pc),
    .off     (in_off),
    .jidx    (in_jidx),
    .seq4    (seq4),
    .seq8    (seq8),
    .br_tgt  (br_tgt),
    .jmp_tgt (jmp_tgt)
  );

  always_comb begin
    nx_taken = 1'b0;
    nx_annul = 1'b0;
    nx_lwe   = 1'b0;
    nx_lidx  = '0;
    nx_pc    = seq4;
    if (is_cond) begin
      nx_taken = hit;
      nx_pc    = hit ? br_tgt : seq8;
      nx_annul = in_likely && !hit;
      if (op == CF_GEZ_LNK || op == CF_LTZ_LNK) begin
        nx_lwe  = 1'b1;
        nx_lidx = LNK_IDX;
      end
    end else begin
      unique case (op)
        CF_JIMM: begin
          nx_taken = 1'b1;
          nx_pc    = jmp_tgt;
        end
        CF_JIMM_LNK: begin
          nx_taken = 1'b1;
          nx_pc    = jmp_tgt;
          nx_lwe   = 1'b1;
          nx_lidx  = LNK_IDX;
        end
        CF_JREG: begin
          nx_taken = 1'b1;
          nx_pc    = in_opa[PC_W-1:0];
        end
        CF_JREG_LNK: begin
          nx_taken = 1'b1;
          nx_pc    = in_opa[PC_W-1:0];
          nx_lwe   = (in_rd != '0);
          nx_lidx  = (in_rd != '0) ? in_rd : '0;
        end
        default: nx_pc = seq4;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_next_pc   <= '0;
      out_taken     <= 1'b0;
      out_annul     <= 1'b0;
      out_link_we   <= 1'b0;
      out_link_idx  <= '0;
      out_link_addr <= '0;
    end else if (in_valid) begin
      out_valid     <= 1'b1;
      out_next_pc   <= nx_pc;
      out_taken     <= nx_taken;
      out_annul     <= nx_annul;
      out_link_we   <= nx_lwe;
      out_link_idx  <= nx_lidx;
      out_link_addr <= nx_lwe ? seq8 : '0;
    end else begin
      out_valid     <= 1'b0;
      out_taken     <= 1'b0;
      out_annul     <= 1'b0;
      out_link_we   <= 1'b0;
      out_link_idx  <= '0;
      out_link_addr <= '0;
    end
  end
endmodule

// File: rtl/bnpc_unit_chk.sv
module bnpc_unit_chk #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [PC_W-1:0]  in_pc,
  input logic [3:0]       in_op,
  input logic             out_valid,
  input logic [PC_W-1:0]  out_next_pc,
  input logic             out_taken,
  input logic             out_annul,
  input logic             out_link_we,
  input logic [REG_W-1:0] out_link_idx,
  input logic [PC_W-1:0]  out_link_addr
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_taken && !out_annul && !out_link_we));

  p_annul_untaken_r6: assert property (@(posedge clk) disable iff (rst)
    out_annul |-> (!out_taken && out_valid));

  p_annul_skip_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid ##1 out_annul) |-> (out_next_pc == $past(in_pc) + PC_W'(8)));

  p_ret_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid ##1 out_link_we) |-> (out_link_addr == $past(in_pc) + PC_W'(8)));

  p_link_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    out_link_we |-> (out_link_idx != '0));

  p_jump_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op >= 4'd9 && in_op <= 4'd12) |=> (out_taken && !out_annul));

  p_seq_step_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == 4'd0 || in_op >= 4'd13)) |=>
      (!out_taken && !out_link_we && out_next_pc == $past(in_pc) + PC_W'(4)));
endmodule

bind bnpc_unit bnpc_unit_chk #(.PC_W(PC_W), .REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_pc         (in_pc),
  .in_op         (in_op),
  .out_valid     (out_valid),
  .out_next_pc   (out_next_pc),
  .out_taken     (out_taken),
  .out_annul     (out_annul),
  .out_link_we   (out_link_we),
  .out_link_idx  (out_link_idx),
  .out_link_addr (out_link_addr)
);

// File: tb/bnpc_unit_tb_top.sv
`timescale 1ns/1ps
module bnpc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_pc;
  logic [3:0]  in_op;
  logic        in_likely;
  logic [15:0] in_off;
  logic [25:0] in_jidx;
  logic [63:0] in_opa, in_opb;
  logic [4:0]  in_rd;
  logic        out_valid, out_taken, out_annul, out_link_we;
  logic [31:0] out_next_pc, out_link_addr;
  logic [4:0]  out_link_idx;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // model state carried across idle cycles
  logic [31:0] m_pc_hold = '0;

  always #2.5 clk = ~clk;

  bnpc_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pc(in_pc), .in_op(in_op),
    .in_likely(in_likely), .in_off(in_off), .in_jidx(in_jidx),
    .in_opa(in_opa), .in_opb(in_opb), .in_rd(in_rd),
    .out_valid(out_valid), .out_next_pc(out_next_pc), .out_taken(out_taken),
    .out_annul(out_annul), .out_link_we(out_link_we),
    .out_link_idx(out_link_idx), .out_link_addr(out_link_addr)
  );

  function automatic string tag_of(input int op, input bit lk);
    if (op == 1 || op == 2) return lk ? "R2/R6" : "R2/R4/R5";
    if (op >= 3 && op <= 6) return lk ? "R3/R6" : "R3/R4/R5";
    if (op == 7 || op == 8) return "R7";
    if (op == 9 || op == 10) return lk ? "R8/R10" : "R8";
    if (op == 11 || op == 12) return lk ? "R9/R10" : "R9";
    return lk ? "R11/R10" : "R11";
  endfunction

  task automatic cmp1(input string tag, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference, then compare one cycle later
  task automatic apply(input bit v, input int op, input bit lk, input logic [31:0] pc,
                       input logic [15:0] off, input logic [25:0] jx,
                       input logic [63:0] a, input logic [63:0] b, input logic [4:0] rd,
                       input string tag);
    longint sa;
    bit cond, t, an, lw;
    int li;
    logic [31:0] npc, la;
    sa = longint'(a);
    cond = 0; t = 0; an = 0; lw = 0; li = 0; la = 0;
    npc = pc + 32'd4;
    case (op)
      1: begin cond = 1; t = (a == b); end
      2: begin cond = 1; t = (a != b); end
      3, 7: begin cond = 1; t = (sa >= 0); end
      4: begin cond = 1; t = (sa > 0); end
      5: begin cond = 1; t = (sa <= 0); end
      6, 8: begin cond = 1; t = (sa < 0); end
      9, 10: begin t = 1; npc = {npc[31:28], jx, 2'b00}; end
      11, 12: begin t = 1; npc = a[31:0]; end
      default: ;
    endcase
    if (cond) begin
      npc = t ? (pc + 32'd4 + 32'(int'($signed(off)) * 4)) : (pc + 32'd8);
      an = lk && !t;
    end
    if (op == 7 || op == 8 || op == 10) begin lw = 1; li = 31; end
    if (op == 12 && rd != 0) begin lw = 1; li = int'(rd); end
    if (lw) la = pc + 32'd8;
    in_valid = v; in_op = 4'(op); in_likely = lk; in_pc = pc; in_off = off;
    in_jidx = jx; in_opa = a; in_opb = b; in_rd = rd;
    @(negedge clk);
    if (v) begin
      m_pc_hold = npc;
      cmp1(tag, "valid", longint'(out_valid), 1);
      cmp1(tag, "next_pc", longint'(out_next_pc), longint'(npc));
      cmp1(tag, "taken", longint'(out_taken), longint'(t));
      cmp1(tag, "annul", longint'(out_annul), longint'(an));
      cmp1(tag, "link_we", longint'(out_link_we), longint'(lw));
      cmp1(tag, "link_idx", longint'(out_link_idx), longint'(li));
      cmp1(tag, "link_addr", longint'(out_link_addr), longint'(la));
    end else begin
      cmp1("R1", "valid", longint'(out_valid), 0);
      cmp1("R1", "next_pc hold", longint'(out_next_pc), longint'(m_pc_hold));
      cmp1("R1", "taken", longint'(out_taken), 0);
      cmp1("R1", "annul", longint'(out_annul), 0);
      cmp1("R1", "link_we", longint'(out_link_we), 0);
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 0; in_pc = 0; in_op = 0; in_likely = 0; in_off = 0;
    in_jidx = 0; in_opa = 0; in_opb = 0; in_rd = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp1("R1", "reset valid", longint'(out_valid), 0);
    cmp1("R1", "reset next_pc", longint'(out_next_pc), 0);
    cmp1("R1", "reset taken", longint'(out_taken), 0);
    cmp1("R1", "reset link_addr", longint'(out_link_addr), 0);
    rst = 1'b0;
    // R2: operands differing only in bit 63 / bit 40
    apply(1, 1, 0, 32'h0000_1000, 16'h0010, 0, 64'h8000_0000_0000_0005, 64'h0000_0000_0000_0005, 0, "R2 eq hi-bit");
    apply(1, 1, 0, 32'h0000_1000, 16'h0010, 0, 64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, 0, "R2 eq match R4");
    apply(1, 2, 0, 32'h0000_2000, 16'hfff0, 0, 64'h0000_0100_0000_0000, 64'h0, 0, "R2 ne bit40 R4 neg off");
    apply(1, 2, 0, 32'h0000_2000, 16'h0004, 0, 64'h77, 64'h77, 0, "R2 ne equal R5");
    // R3: sign and zero tests
    apply(1, 3, 0, 32'h0000_3000, 16'h0002, 0, 64'h0, 64'h0, 0, "R3 gez zero");
    apply(1, 4, 0, 32'h0000_3000, 16'h0002, 0, 64'h0, 64'h0, 0, "R3 gtz zero R5");
    apply(1, 5, 0, 32'h0000_3000, 16'h0002, 0, 64'h8000_0000_0000_0000, 64'h0, 0, "R3 lez most-neg");
    apply(1, 6, 0, 32'h0000_3000, 16'h0002, 0, 64'h0000_0000_8000_0000, 64'h0, 0, "R3 ltz bit31 only");
    apply(1, 4, 0, 32'h0000_3000, 16'h8000, 0, 64'h7fff_ffff_ffff_ffff, 64'h0, 0, "R3 gtz max R4 min off");
    // R6: likely forms
    apply(1, 1, 1, 32'h0000_4000, 16'h0008, 0, 64'h1, 64'h2, 0, "R6 likely not taken");
    apply(1, 1, 1, 32'h0000_4000, 16'h0008, 0, 64'h2, 64'h2, 0, "R6 likely taken");
    // R7: link forms, both outcomes, plus likely
    apply(1, 7, 0, 32'h0000_5000, 16'h0003, 0, 64'hffff_ffff_ffff_ffff, 64'h0, 0, "R7 gez-link not taken");
    apply(1, 8, 0, 32'h0000_5000, 16'h0003, 0, 64'hffff_ffff_ffff_ffff, 64'h0, 0, "R7 ltz-link taken");
    apply(1, 8, 1, 32'h0000_5000, 16'h0003, 0, 64'h5, 64'h0, 0, "R7 R6 ltz-link likely");
    // R1: idle cycles keep next_pc
    apply(0, 2, 1, 32'h0000_9999, 16'h0001, 0, 64'h1, 64'h0, 3, "R1 idle");
    apply(0, 0, 0, 32'h0000_0000, 16'h0000, 0, 64'h0, 64'h0, 0, "R1 idle");
    // R8: direct jumps, top bits from delay-slot address
    apply(1, 9, 0, 32'hAFFF_FFFC, 16'h0, 26'h3ff_ffff, 64'h0, 64'h0, 0, "R8 jump region carry");
    apply(1, 10, 0, 32'h1000_0040, 16'h0, 26'h012_3456, 64'h0, 64'h0, 0, "R8 jump link");
    // R9: register jumps
    apply(1, 11, 0, 32'h0000_6000, 16'h0, 0, 64'hdead_beef_0000_8000, 64'h0, 0, "R9 reg jump");
    apply(1, 12, 0, 32'h0000_6000, 16'h0, 0, 64'h0000_0000_0000_4444, 64'h0, 0, "R9 reg link rd0");
    apply(1, 12, 0, 32'h0000_6010, 16'h0, 0, 64'h0000_0000_0000_5550, 64'h0, 5, "R9 reg link rd5 same reg");
    // R10: likely ignored for jumps and sequential
    apply(1, 9, 1, 32'h0000_7000, 16'h0, 26'h10, 64'h0, 64'h0, 0, "R10 jump likely");
    apply(1, 11, 1, 32'h0000_7000, 16'h0, 0, 64'h100, 64'h0, 0, "R10 reg jump likely");
    // R11: sequential classes
    apply(1, 0, 1, 32'h0000_8000, 16'h0040, 26'h55, 64'h0, 64'h0, 7, "R11 seq likely");
    apply(1, 14, 0, 32'hFFFF_FFFC, 16'h0040, 26'h55, 64'h0, 64'h0, 7, "R11 unused class wrap");
    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      int op;
      bit lk;
      logic [63:0] a, b;
      op = int'($urandom_range(0, 15));
      lk = 1'($urandom_range(0, 1));
      a = {$urandom(), $urandom()};
      case ($urandom_range(0, 4))
        0: a = 64'h0;
        1: b = a;
        default: ;
      endcase
      b = ($urandom_range(0, 2) == 0) ? a : {$urandom(), $urandom()};
      apply(($urandom_range(0, 7) != 0), op, lk, $urandom(), 16'($urandom()),
            26'($urandom()), a, b, 5'($urandom()), tag_of(op, lk));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule